// File: doc/BRIEF.md
# Timer Compare-Output Waveform Generator

This block is an up-counting timer with a single compare channel that produces one waveform on a single output pin. A waveform-generation field selects how the counter runs: free-running over the full counter range, cleared when it reaches the compare value, or fast PWM. In fast PWM the upper count limit is either the all-ones value or the compare value, picked by a top-select bit.

A two-bit output-action code decides what a compare match does to the waveform bit: toggle, clear or set. In fast PWM it also decides what happens when the counter wraps back to zero. When the output-action code is zero, the pin carries the ordinary port data instead of the waveform. The same holds for the fast-PWM toggle code while the counter limit is the all-ones value.

Software reaches the block through a plain write port with three addresses. A count-enable input advances the counter one step per enabled cycle. The pin output-enable simply follows the direction input.

Top module: `cmp_wavegen`

## Requirements
- R1: After reset the control fields, the compare value, the counter and the waveform bit are all 0. The pin therefore shows `port_val`, and `count` reads 0.
- R2: The counter advances by one on every cycle with `cnt_en` high and holds otherwise. In normal mode it runs from 0 to 2^CW-1 and wraps to 0. The mode is set by writing address 0 with bits 1:0 = 00; the codes 01, and 10 with top-select set, also give normal mode.
- R3: In CTC mode (address 0 bits 1:0 = 10, top-select 0), the counter goes to 0 on the enabled step after it equals the compare value. The count period is therefore compare+1.
- R4: In normal and CTC modes, an enabled step taken while the counter equals the compare value acts on the waveform bit according to address 0 bits 7:6. Code 01 toggles it, 10 clears it and 11 sets it. The new level is visible from the next count value onward.
- R5: Fast PWM is selected by address 0 bits 1:0 = 11. The counter limit is 2^CW-1 when top-select (address 1 bit 3) is 0, and the compare value when top-select is 1. After the limit the counter returns to 0.
- R6: In fast PWM with code 10 and a compare value below the limit, the waveform is set when the counter wraps to 0 and cleared after the match. The pin is high exactly while count <= compare.
- R7: In fast PWM with code 11, the waveform is cleared at the wrap and set after the match. The pin is low exactly while count <= compare.
- R8: In fast PWM, code 01 toggles the waveform on a match only when top-select is 1. With top-select 0 the pin shows `port_val` and the waveform bit is left untouched.
- R9: In fast PWM, when the compare value equals the counter limit and bit 7 of address 0 is set, the compare match has no effect. The pin stays at the level set at the wrap: constant high for code 10 and constant low for code 11.
- R10: A compare-value write (address 2) takes effect at once in normal and CTC modes. In fast PWM it is held in a buffer and becomes active on the step that wraps the counter to 0.
- R11: With output code 00, `pin_val` equals `port_val` and the waveform bit keeps its value. When a nonzero code is written again, the pin shows the retained level before any new match.
- R12: `pin_oe` equals `pin_dir` in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 control A, 1 control B, 2 compare value |
| wr_data | input | 8 | Register write data |
| cnt_en | input | 1 | Count-enable, one counter step per cycle when high |
| port_val | input | 1 | Normal port data for the pin |
| pin_dir | input | 1 | Pin direction, 1 = output |
| count | output | CW | Current counter value |
| pin_val | output | 1 | Pin level: waveform or port data |
| pin_oe | output | 1 | Pin output-driver enable |

## Verification
The embedded assertions check several rules on every cycle: the counter holding while disabled, the CTC clear after a match, the fast-PWM compare buffer changing only at a wrap, the bottom set and clear, and the ignored match when compare equals the limit. They also check that the waveform bit stays frozen while disconnected or while the toggle code is inactive. Duty cycles, toggle periods and the exact cycle at which a compare write takes effect can only be shown by the bench's scenarios. The bench sweeps every compare value of a 4-bit instance in both PWM polarities and compares the pin against count <= compare. It also steps through each non-PWM action, the compare-limited modes, the write timing and the reconnect behaviour.

// File: rtl/cwg_pkg.sv
package cwg_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CTC    = 2'd1,
    MODE_FAST   = 2'd2
  } run_mode_e;

  localparam logic [1:0] ADDR_CTRL_A = 2'd0;
  localparam logic [1:0] ADDR_CTRL_B = 2'd1;
  localparam logic [1:0] ADDR_CMP    = 2'd2;

  localparam logic [1:0] ACT_OFF    = 2'b00;
  localparam logic [1:0] ACT_TOGGLE = 2'b01;
  localparam logic [1:0] ACT_CLEAR  = 2'b10;
  localparam logic [1:0] ACT_SET    = 2'b11;

  typedef struct packed {
    logic [1:0] act;
    logic [1:0] wgm_lo;
    logic       top_sel;
  } ctrl_t;

endpackage

// File: rtl/cwg_regs.sv
module cwg_regs #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [DW-1:0]         wr_data,
  output cwg_pkg::ctrl_t        ctrl,
  output cwg_pkg::run_mode_e    mode,
  output logic                  cmp_wr,
  output logic [CW-1:0]         cmp_data
);
  import cwg_pkg::*;

  ctrl_t ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_CTRL_A) begin
        ctrl_q.act    <= wr_data[7:6];
        ctrl_q.wgm_lo <= wr_data[1:0];
      end
      if (wr_addr == ADDR_CTRL_B) begin
        ctrl_q.top_sel <= wr_data[3];
      end
    end
  end

  always_comb begin
    if (ctrl_q.wgm_lo == 2'b11)
      mode = MODE_FAST;
    else if (ctrl_q.wgm_lo == 2'b10 && !ctrl_q.top_sel)
      mode = MODE_CTC;
    else
      mode = MODE_NORMAL;
  end

  assign ctrl     = ctrl_q;
  assign cmp_wr   = wr_en && (wr_addr == ADDR_CMP);
  assign cmp_data = wr_data[CW-1:0];

endmodule

// File: rtl/cwg_counter.sv
module cwg_counter #(
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  cwg_pkg::run_mode_e mode,
  input  logic               top_sel,
  input  logic               cmp_wr,
  input  logic [CW-1:0]      cmp_data,
  output logic [CW-1:0]      count,
  output logic               match,
  output logic               wrap,
  output logic               cmp_is_top
);
  import cwg_pkg::*;

  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cmp_buf;
  logic [CW-1:0] cmp_act;
  logic [CW-1:0] top;

  always_comb begin
    if (mode == MODE_CTC || (mode == MODE_FAST && top_sel))
      top = cmp_act;
    else
      top = CMAX;
  end

  assign wrap       = cnt_en && (cnt_q == top);
  assign match      = cnt_en && (cnt_q == cmp_act);
  assign cmp_is_top = (cmp_act == top);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (cmp_wr)
        cmp_buf <= cmp_data;
      if (mode != MODE_FAST) begin
        if (cmp_wr)
          cmp_act <= cmp_data;
      end else if (wrap) begin
        cmp_act <= cmp_buf;
      end
    end
  end

  assign count = cnt_q;

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(cnt_q));

  a_r3_ctc_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_CTC && cnt_en && cnt_q == cmp_act) |=> (cnt_q == '0));

  a_r10_buffered_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && !wrap) |=> $stable(cmp_act));

endmodule

// File: rtl/cwg_wave.sv
module cwg_wave (
  input  logic               clk,
  input  logic               rst_n,
  input  cwg_pkg::run_mode_e mode,
  input  logic [1:0]         act,
  input  logic               top_sel,
  input  logic               match,
  input  logic               wrap,
  input  logic               cmp_is_top,
  output logic               wave,
  output logic               connected
);
  import cwg_pkg::*;

  logic wave_q;
  logic wave_d;
  logic fast_toggle_off;
  logic match_masked;

  assign fast_toggle_off = (mode == MODE_FAST) && (act == ACT_TOGGLE) && !top_sel;
  assign connected       = (act != ACT_OFF) && !fast_toggle_off;
  assign match_masked    = (mode == MODE_FAST) && act[1] && cmp_is_top;

  always_comb begin
    wave_d = wave_q;
    if (mode == MODE_FAST) begin
      if (wrap) begin
        if (act == ACT_CLEAR) wave_d = 1'b1;
        if (act == ACT_SET)   wave_d = 1'b0;
      end
      if (match && !match_masked) begin
        case (act)
          ACT_TOGGLE: if (top_sel) wave_d = ~wave_q;
          ACT_CLEAR:  wave_d = 1'b0;
          ACT_SET:    wave_d = 1'b1;
          default:    wave_d = wave_q;
        endcase
      end
    end else if (match) begin
      case (act)
        ACT_TOGGLE: wave_d = ~wave_q;
        ACT_CLEAR:  wave_d = 1'b0;
        ACT_SET:    wave_d = 1'b1;
        default:    wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      wave_q <= 1'b0;
    else
      wave_q <= wave_d;
  end

  assign wave = wave_q;

  a_r11_frozen_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_OFF) |=> $stable(wave_q));

  a_r6_bottom_set: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act == ACT_CLEAR && wrap) |=> wave_q);

  a_r7_bottom_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act == ACT_SET && wrap) |=> !wave_q);

  a_r9_match_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act[1] && cmp_is_top && !wrap) |=> $stable(wave_q));

  a_r8_toggle_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAST && act == ACT_TOGGLE && !top_sel) |=> $stable(wave_q));

endmodule

// File: rtl/cmp_wavegen.sv
module cmp_wavegen #(
  parameter int CW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          cnt_en,
  input  logic          port_val,
  input  logic          pin_dir,
  output logic [CW-1:0] count,
  output logic          pin_val,
  output logic          pin_oe
);
  import cwg_pkg::*;

  ctrl_t         ctrl;
  run_mode_e     mode;
  logic          cmp_wr;
  logic [CW-1:0] cmp_data;
  logic          match;
  logic          wrap;
  logic          cmp_is_top;
  logic          wave;
  logic          connected;

  cwg_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl     (ctrl),
    .mode     (mode),
    .cmp_wr   (cmp_wr),
    .cmp_data (cmp_data)
  );

  cwg_counter #(.CW(CW)) u_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .mode       (mode),
    .top_sel    (ctrl.top_sel),
    .cmp_wr     (cmp_wr),
    .cmp_data   (cmp_data),
    .count      (count),
    .match      (match),
    .wrap       (wrap),
    .cmp_is_top (cmp_is_top)
  );

  cwg_wave u_wave (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .act        (ctrl.act),
    .top_sel    (ctrl.top_sel),
    .match      (match),
    .wrap       (wrap),
    .cmp_is_top (cmp_is_top),
    .wave       (wave),
    .connected  (connected)
  );

  assign pin_val = connected ? wave : port_val;
  assign pin_oe  = pin_dir;

  a_r11_port_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.act == ACT_OFF) |-> (pin_val == port_val));

endmodule

// File: tb/cmp_wavegen_test.sv
module cmp_wavegen_test;
  localparam int CW = 4;
  localparam int LIM = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          cnt_en = 1'b0;
  logic          port_val = 1'b1;
  logic          pin_dir = 1'b1;
  logic [CW-1:0] count;
  logic          pin_val;
  logic          pin_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_wavegen #(.CW(CW), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_en(cnt_en), .port_val(port_val), .pin_dir(pin_dir),
    .count(count), .pin_val(pin_val), .pin_oe(pin_oe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // called just after a falling edge; register updates on the next rising edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    do @(negedge clk); while (int'(count) != v);
  endtask

  function automatic logic [7:0] ctl_a(input logic [1:0] act, input logic [1:0] wgm);
    return {act, 4'b0000, wgm};
  endfunction

  initial begin
    int prev_c;
    int prev_p;
    int exp_c;
    int highs;
    int expv;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(int'(count) == 0, "R1 count after reset", int'(count), 0);
    chk(pin_val == 1'b1, "R1 pin shows port data", int'(pin_val), 1);
    port_val = 1'b0;
    @(negedge clk);
    chk(pin_val == 1'b0, "R1 pin follows port data", int'(pin_val), 0);
    chk(pin_oe == 1'b1, "R12 oe follows direction", int'(pin_oe), 1);
    repeat (5) @(negedge clk);
    chk(int'(count) == 0, "R2 holds with count-enable low", int'(count), 0);

    // R2 normal mode free run
    cnt_en = 1'b1;
    @(negedge clk);
    prev_c = int'(count);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      exp_c = (prev_c + 1) % (LIM + 1);
      chk(int'(count) == exp_c, "R2 step and wrap", int'(count), exp_c);
      prev_c = int'(count);
    end
    cnt_en = 1'b0;
    prev_c = int'(count);
    repeat (6) @(negedge clk);
    chk(int'(count) == prev_c, "R2 hold", int'(count), prev_c);
    cnt_en = 1'b1;

    // R4 non-PWM actions, compare = 9
    wr(2'd2, 8'd9);
    wr(2'd0, ctl_a(2'b11, 2'b00));
    wait_cnt(9);
    chk(pin_val == 1'b0, "R4 set not yet applied", int'(pin_val), 0);
    wait_cnt(10);
    chk(pin_val == 1'b1, "R4 set on match", int'(pin_val), 1);
    wr(2'd0, ctl_a(2'b10, 2'b00));
    wait_cnt(10);
    chk(pin_val == 1'b0, "R4 clear on match", int'(pin_val), 0);
    wr(2'd0, ctl_a(2'b01, 2'b00));
    wait_cnt(10);
    chk(pin_val == 1'b1, "R4 toggle first", int'(pin_val), 1);
    wait_cnt(10);
    chk(pin_val == 1'b0, "R4 toggle second", int'(pin_val), 0);

    // R10 immediate compare write in normal mode
    wr(2'd0, ctl_a(2'b11, 2'b00));
    wait_cnt(2);
    wr(2'd2, 8'd5);
    wait_cnt(5);
    chk(pin_val == 1'b0, "R10 before new match", int'(pin_val), 0);
    wait_cnt(6);
    chk(pin_val == 1'b1, "R10 immediate write", int'(pin_val), 1);

    // R3 CTC with toggle (R4)
    cnt_en = 1'b0;
    @(negedge clk);
    wr(2'd2, 8'd5);
    wr(2'd0, ctl_a(2'b01, 2'b10));
    cnt_en = 1'b1;
    wait_cnt(0);
    prev_c = int'(count);
    prev_p = int'(pin_val);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      exp_c = (prev_c == 5) ? 0 : prev_c + 1;
      chk(int'(count) == exp_c, "R3 CTC sequence", int'(count), exp_c);
      chk((int'(pin_val) != prev_p) == (count == 0), "R4 CTC toggle at clear",
          int'(pin_val), (count == 0) ? 1 - prev_p : prev_p);
      prev_c = int'(count);
      prev_p = int'(pin_val);
    end

    // R6 / R7 fast PWM sweep, limit all-ones
    wr(2'd1, 8'h00);
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd0, ctl_a(pol == 0 ? 2'b10 : 2'b11, 2'b11));
      for (int o = 0; o <= LIM; o++) begin
        wr(2'd2, 8'(o));
        wait_cnt(0);
        wait_cnt(0);
        highs = 0;
        for (int i = 0; i <= LIM; i++) begin
          expv = ((int'(count) <= o) ? 1 : 0) ^ pol;
          if (pol == 0)
            chk(int'(pin_val) == expv, "R6 noninverting level", int'(pin_val), expv);
          else
            chk(int'(pin_val) == expv, "R7 inverting level", int'(pin_val), expv);
          highs += int'(pin_val);
          @(negedge clk);
        end
        expv = (pol == 0) ? o + 1 : LIM - o;
        if (o == LIM)
          chk(highs == expv, "R9 compare at limit duty", highs, expv);
        else
          chk(highs == expv, "R6 R7 duty", highs, expv);
      end
    end

    // R8 toggle code inactive with limit all-ones
    wr(2'd0, ctl_a(2'b10, 2'b11));
    wait_cnt(0);
    wait_cnt(0);
    wr(2'd0, ctl_a(2'b01, 2'b11));
    port_val = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(pin_val == 1'b0, "R8 port control low", int'(pin_val), 0);
    end
    port_val = 1'b1;
    @(negedge clk);
    chk(pin_val == 1'b1, "R8 port control high", int'(pin_val), 1);

    // R5 limit from compare, R8 toggle at limit
    wr(2'd1, 8'h08);
    wr(2'd2, 8'd9);
    wait_cnt(0);
    wait_cnt(0);
    prev_c = int'(count);
    prev_p = int'(pin_val);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      exp_c = (prev_c == 9) ? 0 : prev_c + 1;
      chk(int'(count) == exp_c, "R5 compare-limited sequence", int'(count), exp_c);
      chk((int'(pin_val) != prev_p) == (count == 0), "R8 toggle at limit",
          int'(pin_val), (count == 0) ? 1 - prev_p : prev_p);
      prev_c = int'(count);
      prev_p = int'(pin_val);
    end

    // R9 compare equals limit: match ignored
    wr(2'd0, ctl_a(2'b10, 2'b11));
    wait_cnt(0);
    wait_cnt(0);
    for (int i = 0; i < 20; i++) begin
      chk(pin_val == 1'b1, "R9 noninverting held high", int'(pin_val), 1);
      @(negedge clk);
    end
    wr(2'd0, ctl_a(2'b11, 2'b11));
    wait_cnt(0);
    wait_cnt(0);
    for (int i = 0; i < 20; i++) begin
      chk(pin_val == 1'b0, "R9 inverting held low", int'(pin_val), 0);
      @(negedge clk);
    end

    // R10 buffered compare write in fast PWM
    wr(2'd1, 8'h00);
    wr(2'd0, ctl_a(2'b10, 2'b11));
    wr(2'd2, 8'd10);
    wait_cnt(0);
    wait_cnt(0);
    wait_cnt(2);
    wr(2'd2, 8'd3);
    wait_cnt(6);
    chk(pin_val == 1'b1, "R10 old compare until wrap", int'(pin_val), 1);
    wait_cnt(0);
    wait_cnt(6);
    chk(pin_val == 1'b0, "R10 new compare after wrap", int'(pin_val), 0);

    // R11 disconnect and reconnect retains waveform
    wr(2'd0, ctl_a(2'b11, 2'b00));
    wr(2'd2, 8'd4);
    wait_cnt(0);
    wait_cnt(6);
    chk(pin_val == 1'b1, "R11 waveform set before disconnect", int'(pin_val), 1);
    cnt_en = 1'b0;
    port_val = 1'b0;
    wr(2'd0, ctl_a(2'b00, 2'b00));
    chk(pin_val == 1'b0, "R11 port data while off", int'(pin_val), 0);
    port_val = 1'b1;
    @(negedge clk);
    chk(pin_val == 1'b1, "R11 port data follows", int'(pin_val), 1);
    port_val = 1'b0;
    repeat (4) @(negedge clk);
    wr(2'd0, ctl_a(2'b10, 2'b00));
    chk(pin_val == 1'b1, "R11 retained level on reconnect", int'(pin_val), 1);
    port_val = 1'b1;
    @(negedge clk);
    port_val = 1'b0;
    @(negedge clk);
    chk(pin_val == 1'b1, "R11 port data ignored while connected", int'(pin_val), 1);

    // R12 direction
    pin_dir = 1'b0;
    @(negedge clk);
    chk(pin_oe == 1'b0, "R12 oe low", int'(pin_oe), 0);
    pin_dir = 1'b1;
    @(negedge clk);
    chk(pin_oe == 1'b1, "R12 oe high", int'(pin_oe), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule